// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block supervises software by a 7-bit down-counter that software must refresh inside a time window. The peripheral clock is divided by a fixed base divide and a selectable power-of-two prescale to form the counter tick. Software reloads the counter through a small register port. A reload made while the counter still sits above the programmed window value is treated as a fault. A reload with a value whose top bit is clear is also a fault, and so is the counter running down past its half-scale point. Each fault produces a one-cycle reset request, but only once the watchdog has been armed.

An early-warning flag marks the moment the counter reaches half-scale, one tick before the timeout. It can drive an interrupt output. Arming and the interrupt enable are both one-way: software can set them, and only a system reset clears them. While the block is unarmed the counter and the flag still run, but no reset request is ever raised.

The register port has a select strobe, a write strobe, an address, write data and combinational read data. The three registers are CONTROL at address 0, CONFIG at address 1 and STATUS at address 2.

Top module: `winwdog_top`

## Requirements
- R1: After reset the block reads as follows. CONTROL at address 0 reads {armed bit 7 = 0, count bits 6:0 = 0x7F}. CONFIG at address 1 reads {irq enable bit 9 = 0, timebase bits 8:7 = 0, window bits 6:0 = 0x7F}. STATUS at address 2 reads {flag bit 0 = 0}. The reset request and the interrupt outputs are low.
- R2: The counter decrements by one every BASE_DIV × 2^timebase clock cycles and wraps from 0x00 to 0x7F.
- R3: When armed and a tick takes the counter from 0x40 to 0x3F, the reset request is high for exactly the one cycle that follows that edge.
- R4: A write to CONTROL while armed and while the current count is greater than the window value raises the reset request in the next cycle. A write made when the count is at or below the window raises none.
- R5: A write to CONTROL while armed that loads a count below 0x40 raises the reset request in the next cycle. Here "armed" includes arming by that same write.
- R6: Writing 1 to CONTROL bit 7 arms the watchdog, and writing 0 there does not disarm it. While unarmed, no reset request is raised by any cause.
- R7: The flag sets when a tick takes the counter from 0x41 to 0x40, whether or not the interrupt is enabled.
- R8: Writing STATUS with bit 0 = 0 clears the flag. Writing bit 0 = 1 leaves it unchanged. A flag set event in the same cycle wins over a clear.
- R9: Writing 1 to CONFIG bit 9 enables the interrupt, and writing 0 there does not disable it. The interrupt output equals the flag while the enable is set.
- R10: A CONTROL write restarts the prescaler, so the first decrement after a reload comes a full period later.
- R11: When a CONTROL write and a tick fall on the same edge, the written value is loaded and that tick's decrement, flag set and underflow request are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low system reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr, combinational |
| wdg_rst_req | output | 1 | One-cycle system reset request |
| wdg_irq | output | 1 | Early-warning interrupt |

## Verification
The bench builds the block with BASE_DIV = 4 in place of 4096. A tick period is then 4, 8, 16 or 32 clocks, so complete descents from 0x7F through 0x40 and the window waits take a few hundred cycles. This makes every timebase setting, the restart of the prescaler on reload and a reload landing on the exact tick edge reachable well inside the run.

// File: rtl/winwdog_pkg.sv
package winwdog_pkg;
  // register addresses
  localparam int REG_CTRL = 0;
  localparam int REG_CFG  = 1;
  localparam int REG_STAT = 2;
endpackage

// File: rtl/wdg_prescaler.sv
module wdg_prescaler #(
  parameter int BASE_DIV = 4096,
  parameter int TB_W     = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            restart,
  input  logic [TB_W-1:0] tb_sel,
  output logic            tick
);
  localparam int MAX_PERIOD = BASE_DIV << ((1 << TB_W) - 1);
  localparam int PRE_W      = $clog2(MAX_PERIOD);

  logic [PRE_W-1:0] pre_q;

  // terminal count of the prescaler for a given timebase
  function automatic logic [PRE_W-1:0] last_count(input logic [TB_W-1:0] sel);
    int unsigned p;
    p = BASE_DIV << sel;
    return PRE_W'(p - 1);
  endfunction

  assign tick = (pre_q >= last_count(tb_sel));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               pre_q <= '0;
    else if (restart || tick) pre_q <= '0;
    else                      pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/wdg_cfg_regs.sv
module wdg_cfg_regs #(
  parameter int CNT_W = 7,
  parameter int TB_W  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CNT_W-1:0] w_win,
  input  logic [TB_W-1:0]  w_tb,
  input  logic             w_ewi,
  output logic [CNT_W-1:0] win_q,
  output logic [TB_W-1:0]  tb_q,
  output logic             ewi_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q <= '1;
      tb_q  <= '0;
      ewi_q <= 1'b0;
    end else if (we) begin
      win_q <= w_win;
      tb_q  <= w_tb;
      ewi_q <= ewi_q | w_ewi;   // sticky until reset
    end
  end
endmodule

// File: rtl/wdg_core.sv
module wdg_core #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             ctrl_we,
  input  logic [CNT_W-1:0] w_cnt,
  input  logic             w_act,
  input  logic             stat_we,
  input  logic             w_flag,
  input  logic [CNT_W-1:0] window,
  output logic [CNT_W-1:0] cnt_q,
  output logic             active_q,
  output logic             flag_q,
  output logic             rst_req_q,
  output logic             evt_early,
  output logic             evt_low,
  output logic             evt_under,
  output logic             evt_reach
);
  localparam logic [CNT_W-1:0] HALF  = CNT_W'(1 << (CNT_W - 1));
  localparam logic [CNT_W-1:0] ABOVE = CNT_W'((1 << (CNT_W - 1)) + 1);

  function automatic logic below_half(input logic [CNT_W-1:0] v);
    return !v[CNT_W-1];
  endfunction

  function automatic logic [CNT_W-1:0] step_down(input logic [CNT_W-1:0] v);
    return v - 1'b1;
  endfunction

  logic act_next;

  assign act_next  = active_q | (ctrl_we & w_act);
  assign evt_early = ctrl_we && act_next && (cnt_q > window);
  assign evt_low   = ctrl_we && act_next && below_half(w_cnt);
  assign evt_under = !ctrl_we && tick && active_q && (cnt_q == HALF);
  assign evt_reach = !ctrl_we && tick && (cnt_q == ABOVE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '1;
      active_q  <= 1'b0;
      flag_q    <= 1'b0;
      rst_req_q <= 1'b0;
    end else begin
      active_q  <= act_next;
      rst_req_q <= evt_early | evt_low | evt_under;
      if (ctrl_we)   cnt_q <= w_cnt;
      else if (tick) cnt_q <= step_down(cnt_q);
      if (evt_reach)                  flag_q <= 1'b1;
      else if (stat_we && !w_flag)    flag_q <= 1'b0;
    end
  end
endmodule

// File: rtl/winwdog_top.sv
module winwdog_top
  import winwdog_pkg::*;
#(
  parameter int BASE_DIV = 4096,
  parameter int CNT_W    = 7,
  parameter int TB_W     = 2,
  parameter int ADDR_W   = 2,
  parameter int DATA_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              wdg_rst_req,
  output logic              wdg_irq
);
  localparam int ACT_BIT = CNT_W;
  localparam int TB_LO   = CNT_W;
  localparam int TB_HI   = CNT_W + TB_W - 1;
  localparam int EWI_BIT = CNT_W + TB_W;

  logic             ctrl_we, cfg_we, stat_we, tick;
  logic [CNT_W-1:0] cnt_q, win_q;
  logic [TB_W-1:0]  tb_q;
  logic             active_q, flag_q, ewi_q;
  logic             evt_early, evt_low, evt_under, evt_reach;
  logic             wdata_unused;

  assign wdata_unused = ^bus_wdata[DATA_W-1:EWI_BIT+1];

  assign ctrl_we = bus_sel && bus_wr && (bus_addr == ADDR_W'(REG_CTRL));
  assign cfg_we  = bus_sel && bus_wr && (bus_addr == ADDR_W'(REG_CFG));
  assign stat_we = bus_sel && bus_wr && (bus_addr == ADDR_W'(REG_STAT));

  wdg_prescaler #(.BASE_DIV(BASE_DIV), .TB_W(TB_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .restart(ctrl_we), .tb_sel(tb_q), .tick(tick)
  );

  wdg_cfg_regs #(.CNT_W(CNT_W), .TB_W(TB_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we),
    .w_win(bus_wdata[CNT_W-1:0]), .w_tb(bus_wdata[TB_HI:TB_LO]),
    .w_ewi(bus_wdata[EWI_BIT]),
    .win_q(win_q), .tb_q(tb_q), .ewi_q(ewi_q)
  );

  wdg_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .ctrl_we(ctrl_we), .w_cnt(bus_wdata[CNT_W-1:0]), .w_act(bus_wdata[ACT_BIT]),
    .stat_we(stat_we), .w_flag(bus_wdata[0]), .window(win_q),
    .cnt_q(cnt_q), .active_q(active_q), .flag_q(flag_q), .rst_req_q(wdg_rst_req),
    .evt_early(evt_early), .evt_low(evt_low), .evt_under(evt_under), .evt_reach(evt_reach)
  );

  assign wdg_irq = flag_q & ewi_q;

  always_comb begin
    bus_rdata = '0;
    case (int'(bus_addr))
      REG_CTRL: bus_rdata = DATA_W'({active_q, cnt_q});
      REG_CFG:  bus_rdata = DATA_W'({ewi_q, tb_q, win_q});
      REG_STAT: bus_rdata = DATA_W'(flag_q);
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/wdg_checker.sv
module wdg_checker #(
  parameter int CNT_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             ctrl_we,
  input logic [CNT_W-1:0] cnt_q,
  input logic             active_q,
  input logic             flag_q,
  input logic             ewi_q,
  input logic             rst_req
);
  localparam logic [CNT_W-1:0] HALF = CNT_W'(1 << (CNT_W - 1));

  // R6: no request unless armed
  a_r6_req_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> active_q);
  // R6: arming is one-way
  a_r6_arm_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |=> active_q);
  // R9: interrupt enable is one-way
  a_r9_ewi_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ewi_q |=> ewi_q);
  // R7: flag only rises when the count has just reached half-scale
  a_r7_flag_at_half: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> (cnt_q == HALF));
  // R3: armed run-down through half-scale requests a reset
  a_r3_underflow_req: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !ctrl_we && active_q && cnt_q == HALF) |=> rst_req);
  // R2: a tick without a write steps the count down by one
  a_r2_step_down: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !ctrl_we) |=> (cnt_q == CNT_W'($past(cnt_q) - 1'b1)));
  // R10: a reload restarts the prescaler (BASE_DIV of at least 2)
  a_r10_restart: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_we |=> !tick);
endmodule

bind winwdog_top wdg_checker #(.CNT_W(CNT_W)) u_wdg_checker (
  .clk(clk), .rst_n(rst_n), .tick(tick), .ctrl_we(ctrl_we),
  .cnt_q(cnt_q), .active_q(active_q), .flag_q(flag_q), .ewi_q(ewi_q),
  .rst_req(wdg_rst_req)
);

// File: tb/winwdog_top_bench.sv
module winwdog_top_bench;
  localparam int BASE = 4;
  localparam int AW   = 2;
  localparam int DW   = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          bus_sel, bus_wr;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata;
  logic [DW-1:0] bus_rdata;
  logic          wdg_rst_req, wdg_irq;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  winwdog_top #(.BASE_DIV(BASE), .ADDR_W(AW), .DATA_W(DW)) u_winwdog_top (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .wdg_rst_req(wdg_rst_req), .wdg_irq(wdg_irq)
  );

  // behavioural reference model
  int m_cnt, m_act, m_flag, m_win, m_tb, m_ewi, m_pre, m_rst;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 127; m_act = 0; m_flag = 0; m_win = 127;
      m_tb = 0; m_ewi = 0; m_pre = 0; m_rst = 0;
    end else begin
      bit wc, wf, ws, tk, setf;
      int period, d;
      wc = bus_sel && bus_wr && bus_addr == 0;
      wf = bus_sel && bus_wr && bus_addr == 1;
      ws = bus_sel && bus_wr && bus_addr == 2;
      d = int'(bus_wdata);
      period = BASE * (1 << m_tb);
      tk = (m_pre >= period - 1);
      setf = 0;
      m_rst = 0;
      m_pre = (wc || tk) ? 0 : m_pre + 1;
      if (wc) begin
        if ((d >> 7) & 1) m_act = 1;
        if (m_act == 1 && (m_cnt > m_win || (d & 127) < 64)) m_rst = 1;
        m_cnt = d & 127;
      end else if (tk) begin
        if (m_act == 1 && m_cnt == 64) m_rst = 1;
        if (m_cnt == 65) setf = 1;
        m_cnt = (m_cnt + 127) % 128;
      end
      if (setf) m_flag = 1;
      else if (ws && (d & 1) == 0) m_flag = 0;
      if (wf) begin
        m_win = d & 127;
        m_tb  = (d >> 7) & 3;
        if ((d >> 9) & 1) m_ewi = 1;
      end
    end
  end

  function automatic int model_read(input int a);
    case (a)
      0: return (m_act << 7) | m_cnt;
      1: return (m_ewi << 9) | (m_tb << 7) | m_win;
      2: return m_flag;
      default: return 0;
    endcase
  endfunction

  // per-clock comparison, away from the edge
  always begin
    @(posedge clk);
    #5;
    if (rst_n === 1'b1 && !done) begin
      vectors++;
      if (wdg_rst_req !== m_rst[0]) begin
        miscompares++;
        $display("FAIL R3 R4 R5 R6 rst_req got %0b exp %0d at %0t", wdg_rst_req, m_rst, $time);
      end
      if (wdg_irq !== (m_flag[0] & m_ewi[0])) begin
        miscompares++;
        $display("FAIL R9 irq got %0b exp %0d at %0t", wdg_irq, m_flag & m_ewi, $time);
      end
      if (!(bus_sel && bus_wr) && int'(bus_rdata) != model_read(int'(bus_addr))) begin
        miscompares++;
        $display("FAIL R2 R7 rdata addr %0d got %0h exp %0h at %0t",
                 bus_addr, bus_rdata, model_read(int'(bus_addr)), $time);
      end
    end
  end

  task automatic chk(input string tag, input int got, input int exp);
    vectors++;
    if (got != exp) begin
      miscompares++;
      $display("FAIL %s got %0h exp %0h", tag, got, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = DW'(d);
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0; bus_addr = '0;
  endtask

  task automatic rd(input int a, output int v);
    bus_addr = AW'(a);
    #1;
    v = int'(bus_rdata);
  endtask

  task automatic wait_count_le(input int lim);
    int v;
    for (int i = 0; i < 1000; i++) begin
      rd(0, v);
      if ((v & 127) <= lim) break;
      @(negedge clk);
    end
  endtask

  task automatic finish_run;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    miscompares++;
    $display("FAIL R1 watchdog expired got timeout exp completion");
    finish_run();
  end

  initial begin
    int v, n, pulses, at;
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(0, v); chk("R1 ctrl", v, 'h7F);
    rd(1, v); chk("R1 cfg", v, 'h7F);
    rd(2, v); chk("R1 stat", v, 0);
    chk("R1 rst_req", int'(wdg_rst_req), 0);
    chk("R1 irq", int'(wdg_irq), 0);

    // R6/R7 unarmed descent past half-scale: flag sets, no request
    pulses = 0;
    for (int i = 0; i < 400; i++) begin
      rd(0, v);
      if (wdg_rst_req) pulses++;
      if ((v & 127) == 'h3F) break;
      @(negedge clk);
    end
    chk("R6 no request unarmed", pulses, 0);
    rd(2, v); chk("R7 flag set without enable", v, 1);

    // R8 flag clear rules
    wr(2, 1); rd(2, v); chk("R8 write 1 keeps flag", v, 1);
    wr(2, 0); rd(2, v); chk("R8 write 0 clears flag", v, 0);

    // R9 interrupt enable is sticky
    wr(1, 'h27F); chk("R9 irq low with flag clear", int'(wdg_irq), 0);
    wr(1, 'h07F); rd(1, v); chk("R9 enable sticky", v, 'h27F);

    // R6 arm, then try to disarm
    wr(0, 'hFF); chk("R6 arm no request", int'(wdg_rst_req), 0);
    wr(0, 'h7F); rd(0, v); chk("R6 arm sticky", v, 'hFF);

    // R4 early refresh
    wr(1, 'h250);
    wr(0, 'hFF); chk("R4 early refresh request", int'(wdg_rst_req), 1);
    @(negedge clk); chk("R4 request single cycle", int'(wdg_rst_req), 0);

    // R5 low load inside the window
    wait_count_le('h50);
    wr(0, 'h30); chk("R5 low load request", int'(wdg_rst_req), 1);

    // R4 refresh inside window, then R3 run-down
    wr(0, 'h41); chk("R4 in-window refresh no request", int'(wdg_rst_req), 0);
    pulses = 0; at = -1;
    for (int k = 1; k <= 20; k++) begin
      @(negedge clk);
      if (wdg_rst_req) begin pulses++; if (at < 0) at = k; end
    end
    chk("R3 underflow pulse count", pulses, 1);
    chk("R3 underflow cycle", at, 8);
    rd(2, v); chk("R7 flag at half", v, 1);
    chk("R9 irq follows flag", int'(wdg_irq), 1);
    wr(2, 0); chk("R9 irq drops with flag", int'(wdg_irq), 0);

    // R2/R10 timebase 3 and prescaler restart
    wr(1, 'h3FF);
    wr(0, 'h7F);
    repeat (10) @(negedge clk);
    wr(0, 'h7F);
    n = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk); n++;
      rd(0, v);
      if ((v & 127) == 'h7E) break;
    end
    chk("R10 R2 full period after reload", n, 32);

    // R11 reload on the tick edge wins
    repeat (31) @(negedge clk);
    wr(0, 'h7F);
    rd(0, v); chk("R11 write wins over tick", v, 'hFF);
    n = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk); n++;
      rd(0, v);
      if ((v & 127) == 'h7E) break;
    end
    chk("R11 period after coincident reload", n, 32);

    @(negedge clk);
    finish_run();
  end
endmodule